// File: doc/BRIEF.md
# Wide-Word to Byte Packetizer

This block sits between an on-chip producer of wide words and the 8-bit write side of a USB bridge FIFO that forwards bytes to a host. Each word arrives on a valid/ready handshake. The block splits the word into its bytes and writes them out one per clock. A word is never split across a gap in which bytes of another word could enter, so every transfer is a whole number of bytes.

A word can carry an end-of-frame mark. After the last byte of a marked word has gone out, the block raises a one-cycle packet-end strobe. The strobe tells the bridge to close the packet it is filling, even if that packet is short, so the next packet starts on a word boundary. Short packets cost bus throughput, so the strobe appears only when a word asks for it.

The bridge's FIFO-full flag stalls both strobes in the same cycle it is seen. The byte on the data lines is held until the flag drops. The word width is set by a parameter: 16, 32 or 48 bits. A second parameter fixes the byte order.

Top module: `word_byte_packetizer`

## Requirements
- R1: `in_ready` is high exactly when no byte of an earlier word remains to be written and no packet-end strobe is still owed. Out of reset `in_ready` is 1, and `byte_wr` and `pkt_end` are 0.
- R2: A word taken on a clock edge with `in_valid` and `in_ready` both high gives exactly WORD_W/8 cycles with `byte_wr` high. The first of these can be the cycle that follows the edge.
- R3: With MSB_FIRST=0, the k-th written byte of a word is bits [8k+7:8k]. With MSB_FIRST=1, the order is reversed and the first byte is the top byte.
- R4: `byte_wr` is 0 in every cycle in which `fifo_full` is 1.
- R5: While `fifo_full` holds the write off, `byte_out` keeps the pending byte. When the flag clears, writing resumes with that same byte, so no byte is lost or repeated.
- R6: `pkt_end` is 0 in every cycle in which `fifo_full` is 1.
- R7: For a word taken with `in_eof`=1, `pkt_end` is high for exactly one cycle. That cycle is the first cycle without `fifo_full` after the cycle in which the word's last byte was written, and `byte_wr` is never high in it.
- R8: A word taken with `in_eof`=0 produces no `pkt_end`.
- R9: A synchronous reset in the middle of a word drops the rest of its bytes and any owed packet-end strobe. After the reset, `byte_wr` and `pkt_end` stay 0 until a new word is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | WORD_W | Word to serialize |
| in_eof | input | 1 | Close the packet after this word |
| in_valid | input | 1 | `in_word` and `in_eof` are valid |
| in_ready | output | 1 | A word can be taken this cycle |
| fifo_full | input | 1 | Bridge FIFO cannot take a write |
| byte_out | output | 8 | Byte presented to the bridge |
| byte_wr | output | 1 | Write strobe for `byte_out` |
| pkt_end | output | 1 | One-cycle packet-close strobe |

## Verification
The bench builds two instances side by side from the same stimulus. One is 48 bits wide with the low byte sent first. The other is 16 bits wide with the high byte sent first. Together they cover both byte orders, the longest and shortest word, and the case where a 2-byte word finishes and owes its packet-end while a 6-byte word is still draining. Random FIFO-full bursts fall on first bytes, on middle bytes, on last bytes and on the owed packet-end, and a reset is forced in the middle of a word.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  typedef logic [7:0] byte_t;

  function automatic int unsigned cnt_bits(int unsigned nbytes);
    return $clog2(nbytes + 1);
  endfunction
endpackage

// File: rtl/wbp_lane_split.sv
module wbp_lane_split #(
  parameter int WORD_W = 48,
  localparam int NBYTES = WORD_W / 8
) (
  input  logic [WORD_W-1:0]       word,
  output logic [NBYTES-1:0][7:0]  lanes
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lanes[g] = word[8*g +: 8];
  end
endmodule

// File: rtl/wbp_serializer.sv
module wbp_serializer
  import wbp_pkg::*;
#(
  parameter int WORD_W    = 48,
  parameter bit MSB_FIRST = 1'b0,
  localparam int NBYTES = WORD_W / 8,
  localparam int CNT_W  = cnt_bits(NBYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              load_eof,
  input  logic              fifo_full,
  output logic              busy,
  output logic              byte_wr,
  output byte_t             byte_out,
  output logic              frame_done
);
  localparam logic [CNT_W-1:0] NB   = CNT_W'(NBYTES);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(NBYTES - 1);

  logic [WORD_W-1:0]      word_q;
  logic [CNT_W-1:0]       left_q;
  logic                   eof_q;
  logic [CNT_W-1:0]       slot;
  logic [NBYTES-1:0][7:0] lanes;

  wbp_lane_split #(.WORD_W(WORD_W)) u_split (
    .word  (word_q),
    .lanes (lanes)
  );

  assign busy    = (left_q != '0);
  assign byte_wr = busy && !fifo_full;
  assign slot    = busy ? (NB - left_q) : '0;

  if (MSB_FIRST) begin : g_msb
    assign byte_out = lanes[TOP - slot];
  end else begin : g_lsb
    assign byte_out = lanes[slot];
  end

  assign frame_done = byte_wr && (left_q == ONE) && eof_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      left_q <= '0;
      eof_q  <= 1'b0;
    end else if (load) begin
      word_q <= load_word;
      left_q <= NB;
      eof_q  <= load_eof;
    end else if (byte_wr) begin
      left_q <= left_q - ONE;
    end
  end
endmodule

// File: rtl/wbp_end_ctl.sv
module wbp_end_ctl (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic fifo_full,
  output logic pend,
  output logic pkt_end
);
  logic pend_q;

  assign pend    = pend_q;
  assign pkt_end = pend_q && !fifo_full;

  always_ff @(posedge clk) begin
    if (rst)          pend_q <= 1'b0;
    else if (arm)     pend_q <= 1'b1;
    else if (pkt_end) pend_q <= 1'b0;
  end
endmodule

// File: rtl/word_byte_packetizer.sv
module word_byte_packetizer
  import wbp_pkg::*;
#(
  parameter int WORD_W    = 48,
  parameter bit MSB_FIRST = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_eof,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              fifo_full,
  output logic [7:0]        byte_out,
  output logic              byte_wr,
  output logic              pkt_end
);
  logic busy, pend, frame_done, load;

  assign in_ready = !busy && !pend;
  assign load     = in_valid && in_ready;

  wbp_serializer #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_ser (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .load_word  (in_word),
    .load_eof   (in_eof),
    .fifo_full  (fifo_full),
    .busy       (busy),
    .byte_wr    (byte_wr),
    .byte_out   (byte_out),
    .frame_done (frame_done)
  );

  wbp_end_ctl u_end (
    .clk       (clk),
    .rst       (rst),
    .arm       (frame_done),
    .fifo_full (fifo_full),
    .pend      (pend),
    .pkt_end   (pkt_end)
  );
endmodule

// File: rtl/word_byte_packetizer_chk.sv
module word_byte_packetizer_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       fifo_full,
  input logic [7:0] byte_out,
  input logic       byte_wr,
  input logic       pkt_end
);
  a_r4_no_wr_when_full: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !byte_wr);

  a_r6_no_end_when_full: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !pkt_end);

  a_r7_end_single: assert property (@(posedge clk) disable iff (rst)
    pkt_end |=> !pkt_end);

  a_r7_end_alone: assert property (@(posedge clk) disable iff (rst)
    pkt_end |-> (!byte_wr && !in_ready));

  a_r1_ready_idle: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !byte_wr);

  a_r2_load_busies: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  a_r5_hold_when_full: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fifo_full) && !$past(in_ready)) |-> $stable(byte_out));
endmodule

bind word_byte_packetizer word_byte_packetizer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .fifo_full (fifo_full),
  .byte_out  (byte_out),
  .byte_wr   (byte_wr),
  .pkt_end   (pkt_end)
);

// File: tb/test_word_byte_packetizer.sv
module wbp_ref #(
  parameter int WORD_W    = 48,
  parameter bit MSB_FIRST = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  input  logic              eof,
  input  logic              full,
  output logic              exp_ready,
  output logic              exp_wr,
  output logic              exp_end,
  output logic              exp_busy,
  output logic [7:0]        exp_byte
);
  localparam int NB = WORD_W / 8;
  logic [7:0] bytes [0:7];
  integer cnt = 0;
  integer head = 0;
  bit eofw = 0;
  bit pend = 0;

  assign exp_busy  = (cnt > 0);
  assign exp_ready = (cnt == 0) && !pend;
  assign exp_wr    = (cnt > 0) && !full;
  assign exp_end   = pend && !full;
  assign exp_byte  = (head < NB) ? bytes[head] : 8'h00;

  always @(posedge clk) begin
    bit w, e, r;
    if (rst) begin
      cnt = 0; head = 0; pend = 0; eofw = 0;
    end else begin
      w = (cnt > 0) && !full;
      e = pend && !full;
      r = (cnt == 0) && !pend;
      if (w) begin
        head = head + 1;
        cnt  = cnt - 1;
        if (cnt == 0 && eofw) pend = 1;
      end
      if (e) pend = 0;
      if (valid && r) begin
        for (int k = 0; k < NB; k++)
          bytes[k] = MSB_FIRST ? word[8*(NB-1-k) +: 8] : word[8*k +: 8];
        head = 0;
        cnt  = NB;
        eofw = eof;
      end
    end
  end
endmodule

module test_word_byte_packetizer;
  logic clk = 0;
  logic rst = 1;
  logic valid = 0, eof = 0, full = 0;
  logic [47:0] word = '0;
  always #5 clk = ~clk;

  logic a_rdy, a_wr, a_end; logic [7:0] a_byte;
  logic b_rdy, b_wr, b_end; logic [7:0] b_byte;
  logic ea_rdy, ea_wr, ea_end, ea_busy; logic [7:0] ea_byte;
  logic eb_rdy, eb_wr, eb_end, eb_busy; logic [7:0] eb_byte;

  word_byte_packetizer #(.WORD_W(48), .MSB_FIRST(1'b0)) i_word_byte_packetizer (
    .clk(clk), .rst(rst), .in_word(word), .in_eof(eof), .in_valid(valid),
    .in_ready(a_rdy), .fifo_full(full), .byte_out(a_byte), .byte_wr(a_wr), .pkt_end(a_end));

  word_byte_packetizer #(.WORD_W(16), .MSB_FIRST(1'b1)) i_word_byte_packetizer_rev (
    .clk(clk), .rst(rst), .in_word(word[15:0]), .in_eof(eof), .in_valid(valid),
    .in_ready(b_rdy), .fifo_full(full), .byte_out(b_byte), .byte_wr(b_wr), .pkt_end(b_end));

  wbp_ref #(.WORD_W(48), .MSB_FIRST(1'b0)) m_a (
    .clk(clk), .rst(rst), .valid(valid), .word(word), .eof(eof), .full(full),
    .exp_ready(ea_rdy), .exp_wr(ea_wr), .exp_end(ea_end), .exp_busy(ea_busy), .exp_byte(ea_byte));

  wbp_ref #(.WORD_W(16), .MSB_FIRST(1'b1)) m_b (
    .clk(clk), .rst(rst), .valid(valid), .word(word[15:0]), .eof(eof), .full(full),
    .exp_ready(eb_rdy), .exp_wr(eb_wr), .exp_end(eb_end), .exp_busy(eb_busy), .exp_byte(eb_byte));

  integer checks = 0;
  integer fails  = 0;
  bit started = 0;
  bit done = 0;

  task automatic chk(input string lane, input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s lane %s %s: actual %0h expected %0h at %0t", tag, lane, what, act, exp, $time);
    end
  endtask

  task automatic lane_cmp(input string lane, input logic rdy, input logic wr, input logic en,
                          input logic [7:0] bo, input logic erdy, input logic ewr,
                          input logic een, input logic ebusy, input logic [7:0] ebo);
    chk(lane, "R1", "in_ready", {7'd0, rdy}, {7'd0, erdy});
    chk(lane, full ? "R4" : "R2", "byte_wr", {7'd0, wr}, {7'd0, ewr});
    if (ewr) chk(lane, "R3", "byte_out", bo, ebo);
    if (full && ebusy) chk(lane, "R5", "held byte_out", bo, ebo);
    chk(lane, full ? "R6" : (een ? "R7" : "R8"), "pkt_end", {7'd0, en}, {7'd0, een});
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      lane_cmp("w48", a_rdy, a_wr, a_end, a_byte, ea_rdy, ea_wr, ea_end, ea_busy, ea_byte);
      lane_cmp("w16", b_rdy, b_wr, b_end, b_byte, eb_rdy, eb_wr, eb_end, eb_busy, eb_byte);
    end
  end

  task automatic step(input bit v, input bit e, input bit f);
    @(posedge clk); #1;
    valid = v; eof = e; full = f;
    word = {$urandom, $urandom};
  endtask

  initial begin
    repeat (3) @(posedge clk);
    started = 1;
    @(negedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1: state out of reset
    chk("w48", "R1", "reset in_ready", {7'd0, a_rdy}, 8'd1);
    chk("w48", "R1", "reset byte_wr", {7'd0, a_wr}, 8'd0);
    chk("w16", "R1", "reset pkt_end", {7'd0, b_end}, 8'd0);

    for (int i = 0; i < 300; i++) step(1'b1, ($urandom % 4) == 0, 1'b0);
    for (int i = 0; i < 2000; i++)
      step(($urandom % 10) < 7, ($urandom % 10) < 3, ($urandom % 10) < 3);
    for (int i = 0; i < 900; i++) step(1'b1, i[0], (i % 9) < 5);

    // R9: reset in the middle of a 48-bit word marked end-of-frame
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    @(posedge clk); #1 rst = 1;
    @(posedge clk); #1 rst = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("w48", "R9", "byte_wr after reset", {7'd0, a_wr}, 8'd0);
      chk("w48", "R9", "pkt_end after reset", {7'd0, a_end}, 8'd0);
      chk("w16", "R9", "pkt_end after reset", {7'd0, b_end}, 8'd0);
      chk("w48", "R9", "in_ready after reset", {7'd0, a_rdy}, 8'd1);
    end

    for (int i = 0; i < 1500; i++)
      step(($urandom % 10) < 8, ($urandom % 2) == 0, ($urandom % 10) < 4);
    step(1'b0, 1'b0, 1'b0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule